// File: doc/BRIEF.md
# Custom-Instruction Multiply-Accumulate Unit

This unit sits beside the integer pipeline of a 32-bit core and executes a small group of custom instructions that share one private 64-bit accumulator. Each cycle it may receive one instruction word, qualified by a valid strobe, together with the values of the two source registers that the core has already read. Instructions carrying the custom major opcode are decoded here. All other instructions are left to the rest of the core and have no effect on this unit.

The supported operations are: zeroing the accumulator, returning either 32-bit half of it to a destination register, and multiply-accumulate in a 32-bit or 64-bit width with signed or unsigned operands. The 32-bit forms keep only the low 32 bits of the product plus the low accumulator half, and they zero the upper half. The 64-bit forms add the full product to the full accumulator and wrap modulo 2^64. Results reach the register file through a registered write request. Malformed encodings raise a registered illegal-instruction flag.

Top module: `mac_unit`

## Requirements
- R1: Synchronous active-high reset zeroes the accumulator and drives the write enable and the illegal flag low.
- R2: Opcode 7'b0001011 in bits [6:0], funct3 (bits [14:12]) = 0, funct7 (bits [31:25]) = 0, bits [24:7] all zero: the accumulator becomes zero at the next clock edge.
- R3: With funct3 = 0, source fields (bits [24:15]) zero and destination index rd (bits [11:7]) nonzero, funct7 = 1 returns accumulator bits [31:0] and funct7 = 2 returns bits [63:32]. The write request (enable, index rd, data) is valid in the cycle after the instruction is accepted.
- R4: A read of either half with rd = 0 produces no register-file write.
- R5: With funct3 = 1 and funct7 = 0 (unsigned) or 1 (signed), the accumulator becomes the zero-extended 32-bit value (low 32 bits of rs1*rs2 + accumulator bits [31:0]) mod 2^32. The upper half becomes zero.
- R6: With funct3 = 2 and funct7 = 0, the accumulator becomes (acc + unsigned 64-bit product of rs1 and rs2) mod 2^64.
- R7: With funct3 = 2 and funct7 = 1, both sources are taken as two's-complement values and the 64-bit signed product is added to the accumulator modulo 2^64.
- R8: Multiply-accumulate instructions never write the register file.
- R9: A custom-opcode word with any other funct3/funct7 pair, a nonzero source field in a clear or read, a nonzero rd in a clear or MAC, or a nonzero bit [24:15]... pattern outside the encodings above raises the illegal flag in the next cycle. It leaves the accumulator unchanged and writes nothing.
- R10: Words with a different opcode, and any word presented while the valid strobe is low, change nothing and raise no flag.
- R11: A read accepted in the cycle right after a MAC returns the accumulator as already updated by that MAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | Value of first source register |
| rs2_val_i | input | 32 | Value of second source register |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| illegal_o | output | 1 | Illegal custom instruction seen in the previous cycle |

## Verification
The MAC forms are driven with all-ones operands, both extremes of the signed range, and mixed-sign pairs, and a long deterministic pseudo-random sweep follows. All-ones operands separate the signed and unsigned 64-bit forms. Chained large products force the 64-bit sum past 2^64 and expose a missing wrap. Running a 32-bit MAC after the upper half has become nonzero shows whether that half is cleared. Reading both halves after every MAC, with no idle cycle between them, tests that the read sees the updated value. Malformed and foreign words are each followed by reads that show that the accumulator did not change.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int XLEN      = 32;
    localparam int ACC_W     = 2 * XLEN;
    localparam int REG_IDX_W = 5;

    localparam logic [6:0] CUSTOM_OPC = 7'b0001011;

    // funct3 group selectors (decoded by the issuing core's convention)
    localparam logic [2:0] GRP_ACC   = 3'd0;
    localparam logic [2:0] GRP_MAC32 = 3'd1;
    localparam logic [2:0] GRP_MAC64 = 3'd2;

    // funct7 selectors inside the accumulator-access group
    localparam logic [6:0] SEL_CLEAR = 7'd0;
    localparam logic [6:0] SEL_LO    = 7'd1;
    localparam logic [6:0] SEL_HI    = 7'd2;

    typedef enum logic [2:0] {
        K_NONE,
        K_CLEAR,
        K_READ_LO,
        K_READ_HI,
        K_MAC32,
        K_MAC64,
        K_BAD
    } mac_kind_e;

    typedef struct packed {
        mac_kind_e                kind;
        logic                     sgn;
        logic [REG_IDX_W-1:0]     rd;
    } mac_dec_t;

    typedef struct packed {
        logic [6:0]           f7;
        logic [4:0]           src2;
        logic [4:0]           src1;
        logic [2:0]           f3;
        logic [REG_IDX_W-1:0] rd;
        logic [6:0]           opc;
    } instr_fields_t;

    function automatic mac_dec_t decode_word(input logic vld, input logic [XLEN-1:0] word);
        instr_fields_t f;
        mac_dec_t      d;
        logic          srcs_zero;
        logic          rd_zero;
        f         = instr_fields_t'(word);
        d.kind    = K_NONE;
        d.sgn     = 1'b0;
        d.rd      = f.rd;
        srcs_zero = (f.src1 == '0) && (f.src2 == '0);
        rd_zero   = (f.rd == '0);
        if (vld && f.opc == CUSTOM_OPC) begin
            unique case (f.f3)
                GRP_ACC: begin
                    if (!srcs_zero)
                        d.kind = K_BAD;
                    else if (f.f7 == SEL_CLEAR)
                        d.kind = rd_zero ? K_CLEAR : K_BAD;
                    else if (f.f7 == SEL_LO)
                        d.kind = K_READ_LO;
                    else if (f.f7 == SEL_HI)
                        d.kind = K_READ_HI;
                    else
                        d.kind = K_BAD;
                end
                GRP_MAC32, GRP_MAC64: begin
                    if (!rd_zero || (f.f7[6:1] != '0))
                        d.kind = K_BAD;
                    else
                        d.kind = (f.f3 == GRP_MAC32) ? K_MAC32 : K_MAC64;
                    d.sgn = f.f7[0];
                end
                default: d.kind = K_BAD;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/mac_decoder.sv
module mac_decoder
    import mac_pkg::*;
#(
    parameter int W = mac_pkg::XLEN
) (
    input  logic         vld_i,
    input  logic [W-1:0] word_i,
    output mac_kind_e    kind_o,
    output logic         sgn_o,
    output logic [REG_IDX_W-1:0] rd_o
);
    mac_dec_t dec;

    always_comb begin
        dec    = decode_word(vld_i, word_i);
        kind_o = dec.kind;
        sgn_o  = dec.sgn;
        rd_o   = dec.rd;
    end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int W = mac_pkg::XLEN,
    localparam int AW = 2 * W
) (
    input  mac_kind_e     kind_i,
    input  logic          sgn_i,
    input  logic [W-1:0]  op_a_i,
    input  logic [W-1:0]  op_b_i,
    input  logic [AW-1:0] acc_i,
    output logic          acc_we_o,
    output logic [AW-1:0] acc_next_o,
    output logic [W-1:0]  rd_data_o
);
    logic [W-1:0]  half [2];
    logic [AW-1:0] a_x;
    logic [AW-1:0] b_x;
    logic [AW-1:0] prod;
    logic [W-1:0]  narrow_sum;
    logic [AW-1:0] wide_sum;

    // split the accumulator into its two readable halves
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half[h] = acc_i[h*W +: W];
    end

    // one multiplier serves both signedness modes: operands are widened
    // to the accumulator width by sign or zero extension
    always_comb begin
        a_x  = {{W{sgn_i & op_a_i[W-1]}}, op_a_i};
        b_x  = {{W{sgn_i & op_b_i[W-1]}}, op_b_i};
        prod = a_x * b_x;
    end

    assign narrow_sum = prod[W-1:0] + half[0];
    assign wide_sum   = prod + acc_i;

    always_comb begin
        acc_we_o   = 1'b0;
        acc_next_o = acc_i;
        unique case (kind_i)
            K_CLEAR: begin
                acc_we_o   = 1'b1;
                acc_next_o = '0;
            end
            K_MAC32: begin
                acc_we_o   = 1'b1;
                acc_next_o = {{W{1'b0}}, narrow_sum};
            end
            K_MAC64: begin
                acc_we_o   = 1'b1;
                acc_next_o = wide_sum;
            end
            default: ;
        endcase
    end

    assign rd_data_o = (kind_i == K_READ_HI) ? half[1] : half[0];
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
    parameter int AW = mac_pkg::ACC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] d_i,
    output logic [AW-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (we_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/mac_wb_stage.sv
module mac_wb_stage
    import mac_pkg::*;
#(
    parameter int W = mac_pkg::XLEN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mac_kind_e            kind_i,
    input  logic [REG_IDX_W-1:0] rd_i,
    input  logic [W-1:0]         data_i,
    output logic                 we_o,
    output logic [REG_IDX_W-1:0] waddr_o,
    output logic [W-1:0]         wdata_o,
    output logic                 bad_o
);
    logic is_read;
    assign is_read = (kind_i == K_READ_LO) || (kind_i == K_READ_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            we_o    <= 1'b0;
            waddr_o <= '0;
            wdata_o <= '0;
            bad_o   <= 1'b0;
        end else begin
            we_o    <= is_read && (rd_i != '0);
            waddr_o <= rd_i;
            wdata_o <= data_i;
            bad_o   <= (kind_i == K_BAD);
        end
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int W = mac_pkg::XLEN,
    localparam int AW = 2 * W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 instr_valid_i,
    input  logic [31:0]          instr_i,
    input  logic [W-1:0]         rs1_val_i,
    input  logic [W-1:0]         rs2_val_i,
    output logic                 rf_we_o,
    output logic [REG_IDX_W-1:0] rf_waddr_o,
    output logic [W-1:0]         rf_wdata_o,
    output logic                 illegal_o
);
    mac_kind_e            kind;
    logic                 sgn;
    logic [REG_IDX_W-1:0] rd;
    logic                 acc_we;
    logic [AW-1:0]        acc_next;
    logic [AW-1:0]        acc_q;
    logic [W-1:0]         rd_data;

    mac_decoder #(.W(32)) u_dec (
        .vld_i  (instr_valid_i),
        .word_i (instr_i),
        .kind_o (kind),
        .sgn_o  (sgn),
        .rd_o   (rd)
    );

    mac_datapath #(.W(W)) u_dp (
        .kind_i     (kind),
        .sgn_i      (sgn),
        .op_a_i     (rs1_val_i),
        .op_b_i     (rs2_val_i),
        .acc_i      (acc_q),
        .acc_we_o   (acc_we),
        .acc_next_o (acc_next),
        .rd_data_o  (rd_data)
    );

    mac_acc_reg #(.AW(AW)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .we_i (acc_we),
        .d_i  (acc_next),
        .q_o  (acc_q)
    );

    mac_wb_stage #(.W(W)) u_wb (
        .clk     (clk),
        .rst     (rst),
        .kind_i  (kind),
        .rd_i    (rd),
        .data_i  (rd_data),
        .we_o    (rf_we_o),
        .waddr_o (rf_waddr_o),
        .wdata_o (rf_wdata_o),
        .bad_o   (illegal_o)
    );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int W = 32,
    localparam int AW = 2 * W
) (
    input logic          clk,
    input logic          rst,
    input logic          instr_valid_i,
    input logic [31:0]   instr_i,
    input logic          rf_we_o,
    input logic [4:0]    rf_waddr_o,
    input logic          illegal_o,
    input logic [AW-1:0] acc_i
);
    logic custom;
    logic clr_ok;
    logic mac32_ok;
    logic mac_any;

    assign custom   = instr_valid_i && (instr_i[6:0] == 7'b0001011);
    assign clr_ok   = custom && (instr_i[31:7] == '0);
    assign mac32_ok = custom && (instr_i[14:12] == 3'd1) && (instr_i[11:7] == '0)
                      && (instr_i[31:26] == '0);
    assign mac_any  = custom && ((instr_i[14:12] == 3'd1) || (instr_i[14:12] == 3'd2));

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rf_we_o && !illegal_o && acc_i == '0));

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
        clr_ok |=> (acc_i == '0));

    p_no_x0_write_r4: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> (rf_waddr_o != 5'd0));

    p_upper_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        mac32_ok |=> (acc_i[AW-1:W] == '0));

    p_mac_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        mac_any |=> !rf_we_o);

    p_bad_keeps_acc_r9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (acc_i == $past(acc_i)));

    p_bad_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        !(illegal_o && rf_we_o));

    p_idle_keeps_acc_r10: assert property (@(posedge clk) disable iff (rst)
        !custom |=> (acc_i == $past(acc_i)));
endmodule

bind mac_unit mac_unit_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_valid_i (instr_valid_i),
    .instr_i       (instr_i),
    .rf_we_o       (rf_we_o),
    .rf_waddr_o    (rf_waddr_o),
    .illegal_o     (illegal_o),
    .acc_i         (acc_q)
);

// File: tb/mac_unit_tb_top.sv
`timescale 1ns/1ps
module mac_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs1_val_i = '0;
    logic [31:0] rs2_val_i = '0;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        illegal_o;

    always #2.5 clk = ~clk;

    mac_unit dut_i (
        .clk           (clk),
        .rst           (rst),
        .instr_valid_i (instr_valid_i),
        .instr_i       (instr_i),
        .rs1_val_i     (rs1_val_i),
        .rs2_val_i     (rs2_val_i),
        .rf_we_o       (rf_we_o),
        .rf_waddr_o    (rf_waddr_o),
        .rf_wdata_o    (rf_wdata_o),
        .illegal_o     (illegal_o)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  addr;
        logic [31:0] data;
        logic        ill;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    logic [63:0] acc_m = '0;

    localparam logic [6:0] OPC = 7'b0001011;

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] s2,
                                        input logic [4:0] s1, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] opc);
        return {f7, s2, s1, f3, rd, opc};
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // driver: apply one word for one cycle, model it, push the expectation
    task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                         input string req, input logic v = 1'b1);
        exp_t e;
        logic [6:0] f7;
        logic [2:0] f3;
        logic [4:0] rd;
        logic [63:0] pa, pb;
        @(negedge clk);
        instr_valid_i = v;
        instr_i       = w;
        rs1_val_i     = a;
        rs2_val_i     = b;
        e  = '0;
        f7 = w[31:25];
        f3 = w[14:12];
        rd = w[11:7];
        if (v && w[6:0] == OPC) begin
            if (f3 == 3'd0) begin
                if (w[24:15] != 0) e.ill = 1'b1;
                else if (f7 == 7'd0) begin
                    if (rd == 0) acc_m = '0; else e.ill = 1'b1;
                end else if (f7 == 7'd1 || f7 == 7'd2) begin
                    e.we   = (rd != 0);
                    e.addr = rd;
                    e.data = (f7 == 7'd1) ? acc_m[31:0] : acc_m[63:32];
                end else e.ill = 1'b1;
            end else if (f3 == 3'd1 || f3 == 3'd2) begin
                if (rd != 0 || f7 > 7'd1) e.ill = 1'b1;
                else begin
                    if (f7 == 7'd1) begin
                        pa = {{32{a[31]}}, a};
                        pb = {{32{b[31]}}, b};
                    end else begin
                        pa = {32'h0, a};
                        pb = {32'h0, b};
                    end
                    if (f3 == 3'd1)
                        acc_m = {32'h0, 32'(pa * pb) + acc_m[31:0]};
                    else
                        acc_m = acc_m + pa * pb;
                end
            end else e.ill = 1'b1;
        end
        exp_q.push_back(e);
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        instr_valid_i = 1'b0;
        instr_i       = '0;
    endtask

    task automatic rd_both(input string req);
        issue(enc(7'd1, 0, 0, 3'd0, 5'd7, OPC), 32'h0, 32'h0, req);
        issue(enc(7'd2, 0, 0, 3'd0, 5'd9, OPC), 32'h0, 32'h0, req);
    endtask

    // monitor: outputs registered at the edge after a word, sampled 1 ns later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && exp_q.size() > 0) begin
                exp_t  e;
                string t;
                bit    ok;
                e  = exp_q.pop_front();
                t  = tag_q.pop_front();
                ok = (rf_we_o == e.we) && (illegal_o == e.ill) &&
                     (!e.we || (rf_waddr_o == e.addr && rf_wdata_o == e.data));
                check(ok, t, $sformatf("got we=%0b addr=%0d data=%h ill=%0b exp we=%0b addr=%0d data=%h ill=%0b",
                      rf_we_o, rf_waddr_o, rf_wdata_o, illegal_o, e.we, e.addr, e.data, e.ill));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout exp completion");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(rf_we_o == 1'b0 && illegal_o == 1'b0, "R1",
              $sformatf("reset outputs got we=%0b ill=%0b exp 0 0", rf_we_o, illegal_o));
        rd_both("R1");

        // R3 with distinct destinations, R6 unsigned wrap of the 64-bit sum
        issue(enc(7'd0, 5'd1, 5'd2, 3'd2, 5'd0, OPC), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
        rd_both("R11");
        issue(enc(7'd0, 5'd1, 5'd2, 3'd2, 5'd0, OPC), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
        issue(enc(7'd0, 5'd1, 5'd2, 3'd2, 5'd0, OPC), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
        issue(enc(7'd1, 0, 0, 3'd0, 5'd31, OPC), 0, 0, "R3");
        issue(enc(7'd2, 0, 0, 3'd0, 5'd1, OPC), 0, 0, "R3");

        // R5: 32-bit form with a nonzero upper half beforehand
        issue(enc(7'd0, 5'd3, 5'd4, 3'd1, 5'd0, OPC), 32'h1234_5678, 32'h9ABC_DEF0, "R5");
        rd_both("R5");
        issue(enc(7'd1, 5'd3, 5'd4, 3'd1, 5'd0, OPC), 32'h8000_0000, 32'hFFFF_FFFF, "R5");
        rd_both("R5");

        // R2 clear
        issue(enc(7'd0, 0, 0, 3'd0, 5'd0, OPC), 0, 0, "R2");
        rd_both("R2");

        // R7 signed extremes
        issue(enc(7'd1, 5'd1, 5'd2, 3'd2, 5'd0, OPC), 32'h8000_0000, 32'h8000_0000, "R7");
        rd_both("R7");
        issue(enc(7'd1, 5'd1, 5'd2, 3'd2, 5'd0, OPC), 32'h8000_0000, 32'h7FFF_FFFF, "R7");
        rd_both("R7");
        issue(enc(7'd1, 5'd1, 5'd2, 3'd2, 5'd0, OPC), 32'hFFFF_FFFF, 32'h0000_0001, "R7");
        issue(enc(7'd1, 5'd1, 5'd2, 3'd2, 5'd0, OPC), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
        rd_both("R7");

        // R4 reads to x0
        issue(enc(7'd1, 0, 0, 3'd0, 5'd0, OPC), 0, 0, "R4");
        issue(enc(7'd2, 0, 0, 3'd0, 5'd0, OPC), 0, 0, "R4");

        // R9 malformed words, each followed by a read
        issue(enc(7'd0, 0, 0, 3'd3, 5'd0, OPC), 32'h5, 32'h7, "R9");
        issue(enc(7'd3, 0, 0, 3'd0, 5'd4, OPC), 0, 0, "R9");
        issue(enc(7'd0, 0, 0, 3'd0, 5'd2, OPC), 0, 0, "R9");
        rd_both("R9");
        issue(enc(7'd0, 5'd1, 5'd2, 3'd2, 5'd3, OPC), 32'h11, 32'h22, "R9");
        issue(enc(7'd2, 5'd1, 5'd2, 3'd1, 5'd0, OPC), 32'h11, 32'h22, "R9");
        issue(enc(7'd1, 5'd6, 0, 3'd0, 5'd8, OPC), 0, 0, "R9");
        issue(enc(7'd0, 0, 5'd1, 3'd0, 5'd0, OPC), 0, 0, "R9");
        rd_both("R9");

        // R10 foreign opcode and valid low
        issue(enc(7'd0, 5'd1, 5'd2, 3'd0, 5'd0, 7'b0110011), 32'h3, 32'h3, "R10");
        issue(enc(7'd0, 5'd1, 5'd2, 3'd2, 5'd0, OPC), 32'hFFFF, 32'hFFFF, "R10", 1'b0);
        issue(enc(7'd5, 0, 0, 3'd7, 5'd0, OPC), 0, 0, "R10", 1'b0);
        rd_both("R10");

        // sweep of mixed MAC forms, each read back at once (R11)
        lf = 32'hACE1_2345;
        for (int i = 0; i < 48; i++) begin
            logic [31:0] a, b;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a  = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            b  = lf ^ 32'h5A5A_0F0F;
            issue(enc({6'd0, i[0]}, 5'd1, 5'd2, (i % 3 == 2) ? 3'd1 : 3'd2, 5'd0, OPC), a, b,
                  (i % 3 == 2) ? "R5" : (i[0] ? "R7" : "R6"));
            rd_both("R11");
        end

        idle();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule